// File: doc/BRIEF.md
# Word-to-Byte Bus Bridge with Address Decode

This block sits on the 16-bit memory bus of a processor that drives only a word address (15 bits). It sorts every access into one of eight 8 KB regions and, inside the I/O region, into per-device ports. Wide memories are selected directly and answer in the same cycle. An access to an 8-bit peripheral becomes two byte cycles on a narrow side bus. During those byte cycles the bridge holds the processor with a ready line and drives the missing lowest address bit itself.

Each I/O device owns a pair of ports 1 KB apart: the lower one serves reads and the upper one serves writes. Selects are qualified by the memory enable and the read strobe, so a read port and a write port are never active together. For a read, the two bytes are assembled into the word before the processor is released. The bench controls the processor bus and models the peripherals.

Top module: `wide_narrow_bridge`

## Requirements
- R1: With `cpu_mem_en` high, byte addresses 0x0000-0x1FFF assert `rom_sel`, 0x6000-0x7FFF assert `cart_sel`, and 0x8000-0x83FF assert `ram_sel`. No select is active while `cpu_mem_en` is low.
- R2: Accesses to the ROM, cartridge and scratchpad RAM ranges keep `cpu_ready` high and produce no byte strobe. On a read, `cpu_rdata` equals `wide_rdata` in the same cycle.
- R3: In 0x8400-0x9FFF, byte address bits [12:11] give the device index d and bit 10 marks the write port. A read with bit 10 clear asserts `io_rd_sel[d]` for d = 1..3. A write with bit 10 set asserts `io_wr_sel[d]` for d = 0..3 (0 = sound at 0x8400, 2 = speech write at 0x9400, 3 = serial ROM address/data write at 0x9C00-0x9FFF, serial ROM read at 0x9800). A read select and a write select are never both active, and `io_rd_sel[0]` never asserts.
- R4: An access that hits an I/O port in its own direction drives `cpu_ready` low in the cycle `cpu_mem_en` rises. It keeps `cpu_ready` low until the byte sequence ends.
- R5: The byte sequence is two strobes, each `STB_CLKS` cycles long (default 2). The first strobe has `byte_a0`=0 and, on a write, `byte_wdata` = `cpu_wdata[15:8]`. The second has `byte_a0`=1 and `byte_wdata` = `cpu_wdata[7:0]`. `byte_rd_stb` is used for reads and `byte_wr_stb` for writes, never both.
- R6: On a read, once `cpu_ready` returns high, `cpu_rdata` = {byte read under `byte_a0`=0, byte read under `byte_a0`=1}.
- R7: `cpu_ready` rises in the cycle right after the second strobe ends. The stall therefore lasts 2*`STB_CLKS`+1 cycles counted from the cycle `cpu_mem_en` rises.
- R8: Regions 0x2000-0x5FFF and 0xA000-0xFFFF, a read from a write port, and a write to an I/O read port all assert no select and no strobe and keep `cpu_ready` high. Reads among them return 0xFFFF.
- R9: While reset is asserted, and right after it, `cpu_ready` is high and both byte strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_waddr | input | 15 | Word address (byte address bits 15:1) |
| cpu_wdata | input | 16 | Write data from processor |
| cpu_mem_en | input | 1 | Memory cycle enable |
| cpu_rd | input | 1 | High for read, low for write |
| cpu_rdata | output | 16 | Read data to processor |
| cpu_ready | output | 1 | Low stalls the processor |
| wide_rdata | input | 16 | Read data from the wide memories |
| rom_sel | output | 1 | Program ROM select |
| cart_sel | output | 1 | Cartridge port select |
| ram_sel | output | 1 | Scratchpad RAM select |
| io_rd_sel | output | 4 | Per-device read port selects |
| io_wr_sel | output | 4 | Per-device write port selects |
| byte_a0 | output | 1 | Generated lowest byte address bit |
| byte_rd_stb | output | 1 | Byte read strobe |
| byte_wr_stb | output | 1 | Byte write strobe |
| byte_wdata | output | 8 | Byte write data |
| byte_rdata | input | 8 | Byte read data from peripherals |

## Verification
The bench hits region boundaries and every port pair in both directions, because reads from write ports and writes to read ports are the easiest cases to decode wrongly. A decoder that ignored the read strobe would select both ports of a pair or start a sequence nobody answers. The bench counts the stall cycle by cycle: an off-by-one in the strobe counter, or releasing ready on the last strobe cycle instead of the cycle after, shows up as a wrong wait count. Distinct random high and low bytes expose swapped byte order or a capture on the wrong cycle. Wide-region hits confirm that ROM and RAM never stall.

// File: rtl/wnb_pkg.sv
package wnb_pkg;

   // sequencer phases of a split word access
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HI   = 2'd1,
      PH_LO   = 2'd2,
      PH_DONE = 2'd3
   } wnb_phase_e;

   // region numbers from the top three byte address bits
   localparam logic [2:0] RGN_ROM  = 3'd0;
   localparam logic [2:0] RGN_CART = 3'd3;
   localparam logic [2:0] RGN_IO   = 3'd4;

endpackage

// File: rtl/wnb_decode.sv
module wnb_decode
   import wnb_pkg::*;
#(
   parameter int ADDR_W  = 15,
   parameter int IO_DEVS = 4
) (
   input  logic [ADDR_W-1:0]  waddr,
   input  logic               mem_en,
   input  logic               rd,
   output logic               rom_sel,
   output logic               cart_sel,
   output logic               ram_sel,
   output logic [IO_DEVS-1:0] io_rd_sel,
   output logic [IO_DEVS-1:0] io_wr_sel,
   output logic               byte_req,
   output logic               wide_hit
);
   localparam int DEV_W   = $clog2(IO_DEVS);
   localparam int RGN_LSB = ADDR_W - 3;
   localparam int DEV_MSB = RGN_LSB - 1;
   localparam int WR_BIT  = DEV_MSB - DEV_W;

   generate
      if (ADDR_W != 15) begin : g_bad_aw
         $error("wnb_decode: ADDR_W must describe a 64 KB byte space");
      end
      if ((1 << DEV_W) != IO_DEVS || IO_DEVS < 2) begin : g_bad_devs
         $error("wnb_decode: IO_DEVS must be a power of two, at least 2");
      end
   endgenerate

   logic [2:0]       region;
   logic [DEV_W-1:0] dev;
   logic             wr_port;
   logic             io_rgn;

   assign region  = waddr[ADDR_W-1:RGN_LSB];
   assign dev     = waddr[DEV_MSB -: DEV_W];
   assign wr_port = waddr[WR_BIT];
   assign io_rgn  = mem_en && (region == RGN_IO);

   assign rom_sel  = mem_en && (region == RGN_ROM);
   assign cart_sel = mem_en && (region == RGN_CART);
   assign ram_sel  = io_rgn && (dev == '0) && !wr_port;
   assign wide_hit = rom_sel || cart_sel || ram_sel;

   // one read port and one write port per device; read slot 0 is the RAM
   for (genvar d = 0; d < IO_DEVS; d++) begin : g_port
      if (d == 0) begin : g_slot0
         assign io_rd_sel[d] = 1'b0;
      end else begin : g_rd
         assign io_rd_sel[d] = io_rgn && (dev == DEV_W'(d)) && !wr_port && rd;
      end
      assign io_wr_sel[d] = io_rgn && (dev == DEV_W'(d)) && wr_port && !rd;
   end

   assign byte_req = (|io_rd_sel) || (|io_wr_sel);

endmodule

// File: rtl/wnb_sequencer.sv
module wnb_sequencer
   import wnb_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int STB_CLKS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                rd,
   input  logic [2*BYTE_W-1:0] wdata,
   input  logic [BYTE_W-1:0]   byte_rdata,
   output logic                ready,
   output logic                rd_stb,
   output logic                wr_stb,
   output logic                a0,
   output logic [BYTE_W-1:0]   byte_wdata,
   output logic [2*BYTE_W-1:0] word
);
   localparam int CW = (STB_CLKS > 1) ? $clog2(STB_CLKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(STB_CLKS - 1);

   generate
      if (STB_CLKS < 1) begin : g_bad_stb
         $error("wnb_sequencer: STB_CLKS must be at least 1");
      end
   endgenerate

   wnb_phase_e        phase;
   logic [CW-1:0]     cnt;
   logic [BYTE_W-1:0] hi_q, lo_q;
   logic              active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         hi_q  <= '0;
         lo_q  <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               phase <= PH_HI;
               cnt   <= '0;
            end
            PH_HI: if (cnt == LAST) begin
               hi_q  <= byte_rdata;
               phase <= PH_LO;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
            PH_LO: if (cnt == LAST) begin
               lo_q  <= byte_rdata;
               phase <= PH_DONE;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: if (!start) phase <= PH_IDLE;
         endcase
      end
   end

   assign active     = (phase == PH_HI) || (phase == PH_LO);
   assign rd_stb     = active && rd;
   assign wr_stb     = active && !rd;
   assign a0         = (phase == PH_LO);
   assign byte_wdata = a0 ? wdata[BYTE_W-1:0] : wdata[2*BYTE_W-1:BYTE_W];
   assign ready      = !(((phase == PH_IDLE) && start) || active);
   assign word       = {hi_q, lo_q};

   // R5: the low byte strobe starts only straight after the high byte strobe
   assert_lo_after_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a0) |-> $past(rd_stb || wr_stb) && (rd_stb || wr_stb));

   // R5: read and write strobes never overlap
   assert_stb_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && wr_stb));

   // R7: ready is released only in the cycle after a low byte strobe
   assert_ready_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(a0));

endmodule

// File: rtl/wide_narrow_bridge.sv
module wide_narrow_bridge
   import wnb_pkg::*;
#(
   parameter int ADDR_W   = 15,
   parameter int BYTE_W   = 8,
   parameter int IO_DEVS  = 4,
   parameter int STB_CLKS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   cpu_waddr,
   input  logic [2*BYTE_W-1:0] cpu_wdata,
   input  logic                cpu_mem_en,
   input  logic                cpu_rd,
   output logic [2*BYTE_W-1:0] cpu_rdata,
   output logic                cpu_ready,
   input  logic [2*BYTE_W-1:0] wide_rdata,
   output logic                rom_sel,
   output logic                cart_sel,
   output logic                ram_sel,
   output logic [IO_DEVS-1:0]  io_rd_sel,
   output logic [IO_DEVS-1:0]  io_wr_sel,
   output logic                byte_a0,
   output logic                byte_rd_stb,
   output logic                byte_wr_stb,
   output logic [BYTE_W-1:0]   byte_wdata,
   input  logic [BYTE_W-1:0]   byte_rdata
);
   localparam int DATA_W = 2 * BYTE_W;

   logic              byte_req, wide_hit;
   logic [DATA_W-1:0] seq_word;

   wnb_decode #(.ADDR_W(ADDR_W), .IO_DEVS(IO_DEVS)) u_dec (
      .waddr     (cpu_waddr),
      .mem_en    (cpu_mem_en),
      .rd        (cpu_rd),
      .rom_sel   (rom_sel),
      .cart_sel  (cart_sel),
      .ram_sel   (ram_sel),
      .io_rd_sel (io_rd_sel),
      .io_wr_sel (io_wr_sel),
      .byte_req  (byte_req),
      .wide_hit  (wide_hit)
   );

   wnb_sequencer #(.BYTE_W(BYTE_W), .STB_CLKS(STB_CLKS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (byte_req),
      .rd         (cpu_rd),
      .wdata      (cpu_wdata),
      .byte_rdata (byte_rdata),
      .ready      (cpu_ready),
      .rd_stb     (byte_rd_stb),
      .wr_stb     (byte_wr_stb),
      .a0         (byte_a0),
      .byte_wdata (byte_wdata),
      .word       (seq_word)
   );

   always_comb begin
      if (wide_hit)      cpu_rdata = wide_rdata;
      else if (byte_req) cpu_rdata = seq_word;
      else               cpu_rdata = '1;
   end

   // R2: wide regions never stall and never strobe the byte bus
   assert_wide_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_mem_en && cpu_waddr[ADDR_W-1 -: 3] == 3'd0)
      |-> cpu_ready && rom_sel && !byte_rd_stb && !byte_wr_stb);

   // R3: no read port alongside a write port, and no read port on a write
   assert_port_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !((|io_rd_sel) && (|io_wr_sel)) && !((|io_rd_sel) && !cpu_rd));

   // R8: empty regions select nothing, answer all ones and do not stall
   assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_mem_en && cpu_waddr[ADDR_W-1 -: 3] inside {3'd1, 3'd2, 3'd5, 3'd6, 3'd7})
      |-> cpu_ready && !rom_sel && !cart_sel && !ram_sel
          && (io_rd_sel == '0) && (io_wr_sel == '0) && (cpu_rdata == '1));

   // R1: no select without a memory cycle
   assert_idle_no_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_mem_en |-> !rom_sel && !cart_sel && !ram_sel
                      && (io_rd_sel == '0) && (io_wr_sel == '0));

endmodule

// File: tb/tb_wide_narrow_bridge.sv
module tb_wide_narrow_bridge;
   localparam int STB = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] cpu_waddr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_mem_en = 1'b0;
   logic        cpu_rd = 1'b1;
   logic [15:0] cpu_rdata;
   logic        cpu_ready;
   logic [15:0] wide_rdata = '0;
   logic        rom_sel, cart_sel, ram_sel;
   logic [3:0]  io_rd_sel, io_wr_sel;
   logic        byte_a0, byte_rd_stb, byte_wr_stb;
   logic [7:0]  byte_wdata, byte_rdata;
   logic [7:0]  hi_b = '0, lo_b = '0;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   // peripheral model: byte picked by the generated address bit
   assign byte_rdata = byte_a0 ? lo_b : hi_b;

   wide_narrow_bridge #(.STB_CLKS(STB)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
      .cpu_mem_en(cpu_mem_en), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
      .cpu_ready(cpu_ready), .wide_rdata(wide_rdata), .rom_sel(rom_sel),
      .cart_sel(cart_sel), .ram_sel(ram_sel), .io_rd_sel(io_rd_sel),
      .io_wr_sel(io_wr_sel), .byte_a0(byte_a0), .byte_rd_stb(byte_rd_stb),
      .byte_wr_stb(byte_wr_stb), .byte_wdata(byte_wdata), .byte_rdata(byte_rdata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected decode: [12]rom [11]cart [10]ram [9:6]rd_sel [5:2]wr_sel [1]byte [0]wide
   function automatic logic [12:0] exp_dec(input logic [15:0] a, input logic rd);
      logic [12:0] e = '0;
      logic [1:0]  d = a[12:11];
      case (a[15:13])
         3'd0: e[12] = 1'b1;
         3'd3: e[11] = 1'b1;
         3'd4: begin
            if (d == 2'd0 && !a[10]) e[10] = 1'b1;
            else if (rd && !a[10]) e[6 + d] = 1'b1;
            else if (!rd && a[10]) e[2 + d] = 1'b1;
         end
         default: ;
      endcase
      e[1] = |e[9:2];
      e[0] = |e[12:10];
      return e;
   endfunction

   task automatic access(input logic [15:0] ba, input logic rd, input logic [15:0] wd);
      logic [12:0] e;
      logic [15:0] wr_mem;
      @(negedge clk);
      cpu_waddr  = ba[15:1];
      cpu_rd     = rd;
      cpu_wdata  = wd;
      wr_mem     = 16'($urandom);
      wide_rdata = wr_mem;
      hi_b       = 8'($urandom);
      lo_b       = 8'($urandom);
      cpu_mem_en = 1'b1;
      #1;
      e = exp_dec(ba, rd);
      check({rom_sel, cart_sel, ram_sel} == e[12:10], "R1 wide selects",
            {29'd0, rom_sel, cart_sel, ram_sel}, {29'd0, e[12:10]});
      check({io_rd_sel, io_wr_sel} == e[9:2], "R3 port selects",
            {24'd0, io_rd_sel, io_wr_sel}, {24'd0, e[9:2]});
      if (e[1]) begin
         check(cpu_ready == 1'b0, "R4 stall at start", cpu_ready, 0);
         for (int k = 1; k <= 2 * STB + 1; k++) begin
            @(negedge clk);
            if (k <= 2 * STB) begin
               check(cpu_ready == 1'b0, "R4 stall held", cpu_ready, 0);
               check(byte_rd_stb == rd && byte_wr_stb == !rd, "R5 strobe kind",
                     {byte_rd_stb, byte_wr_stb}, {rd, !rd});
               check(byte_a0 == (k > STB), "R5 byte order", byte_a0, (k > STB));
               if (!rd)
                  check(byte_wdata == ((k > STB) ? wd[7:0] : wd[15:8]), "R5 byte data",
                        byte_wdata, (k > STB) ? wd[7:0] : wd[15:8]);
            end else begin
               check(cpu_ready == 1'b1, "R7 release cycle", cpu_ready, 1);
               check(!byte_rd_stb && !byte_wr_stb, "R7 strobes ended",
                     {byte_rd_stb, byte_wr_stb}, 0);
               if (rd)
                  check(cpu_rdata == {hi_b, lo_b}, "R6 assembled word", cpu_rdata,
                        {hi_b, lo_b});
            end
         end
      end else if (e[0]) begin
         check(cpu_ready && !byte_rd_stb && !byte_wr_stb, "R2 no stall",
               {cpu_ready, byte_rd_stb, byte_wr_stb}, 3'b100);
         if (rd) check(cpu_rdata == wr_mem, "R2 wide data", cpu_rdata, wr_mem);
      end else begin
         check(cpu_ready && !byte_rd_stb && !byte_wr_stb, "R8 no stall",
               {cpu_ready, byte_rd_stb, byte_wr_stb}, 3'b100);
         if (rd) check(cpu_rdata == 16'hFFFF, "R8 all ones", cpu_rdata, 16'hFFFF);
         @(negedge clk);
         check(!byte_rd_stb && !byte_wr_stb && cpu_ready, "R8 no sequence",
               {cpu_ready, byte_rd_stb, byte_wr_stb}, 3'b100);
      end
      @(negedge clk);
      cpu_mem_en = 1'b0;
      #1;
      check(cpu_ready && {rom_sel, cart_sel, ram_sel, io_rd_sel, io_wr_sel} == '0,
            "R1 idle no select", {cpu_ready, rom_sel, io_rd_sel, io_wr_sel}, 10'h200);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(cpu_ready && !byte_rd_stb && !byte_wr_stb, "R9 in reset",
            {cpu_ready, byte_rd_stb, byte_wr_stb}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      check(cpu_ready && !byte_rd_stb && !byte_wr_stb, "R9 after reset",
            {cpu_ready, byte_rd_stb, byte_wr_stb}, 3'b100);

      // directed corners
      access(16'h0000, 1'b1, 16'h0);      // ROM start
      access(16'h1FFE, 1'b1, 16'h0);      // ROM end
      access(16'h2000, 1'b1, 16'h0);      // empty region
      access(16'h6000, 1'b1, 16'h0);      // cartridge
      access(16'h83FE, 1'b0, 16'h1234);   // RAM end
      access(16'h8400, 1'b0, 16'h9FA5);   // sound write
      access(16'h8400, 1'b1, 16'h0);      // read of write-only port
      access(16'h9400, 1'b0, 16'h70C3);   // speech write
      access(16'h9800, 1'b1, 16'h0);      // serial ROM read
      access(16'h9C02, 1'b0, 16'h0020);   // serial ROM address write
      access(16'h9800, 1'b0, 16'h5555);   // write to read port
      access(16'h8800, 1'b1, 16'h0);      // device 1 read
      access(16'hA000, 1'b1, 16'h0);      // empty upper region
      access(16'hFFFE, 1'b0, 16'hBEEF);

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         case ($urandom % 3)
            0: a = 16'($urandom);
            1: a = {3'b100, 13'($urandom)};
            default: a = {3'b100, 2'($urandom), 1'($urandom), 10'($urandom % 4)};
         endcase
         a[0] = 1'b0;
         access(a, 1'($urandom), 16'($urandom));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule